// File: doc/BRIEF.md
# I2C SCL Phase Timer

This block paces the clock line of an I2C master. It alternates a driven-low phase and a released-high phase. Each phase lasts a programmable number of count ticks. A count tick is the input clock divided by a programmable prescale factor. The byte engine uses two one-cycle strobes from this block. The strobe at the start of each low phase is where SDA may change. The strobe at the start of each confirmed high phase is where SDA is sampled.

The low phase is timed from the cycle in which the block starts driving SCL low. The high phase is timed only from the cycle after SCL is actually seen high on the sampled input. A slow rising edge or a slave holding SCL low therefore lengthens the period and never shortens the high time. If SCL is seen low while the high phase is being timed, the block returns to the low phase at once. This covers clock stretching and another master pulling the line.

Each phase count is nine bits wide. The upper bit arrives on its own input, separate from the lower eight bits. A build-time parameter selects a variant that has no upper bit. In that variant the extension inputs are ignored and both counts are limited to 255.

Top module: `i2c_scl_pacer`

## Requirements
- R1: While in reset, and while run_i is low, scl_drive_low_o, low_stb_o and high_stb_o are all 0. Starting from any state, the cycle after run_i is sampled low shows all three at 0.
- R2: The low phase begins at the clock edge where run_i is first sampled high, or where the high phase ends. scl_drive_low_o stays 1 for exactly L*D cycles, where L = {lo_ext_i, lo_base_i} is the effective low count and D is the effective prescale.
- R3: After the block releases SCL, it waits for scl_i to be sampled high and then times H*D cycles, where H = {hi_ext_i, hi_base_i}. The released time is therefore (cycles spent waiting with scl_i low, at least 1) + H*D.
- R4: Bit 8 of each count comes from lo_ext_i or hi_ext_i. With EXT_EN=1, counts from 256 to 511 give phases of that many ticks.
- R5: A count value of 0 acts as 1, so every phase lasts at least one tick.
- R6: A tick occurs every D input clock cycles, where D = prescale_i. A prescale_i of 0 acts as 1.
- R7: If scl_i is sampled low while the high phase is being timed, the next cycle shows scl_drive_low_o = 1 and low_stb_o = 1. A full low phase of L*D cycles follows.
- R8: low_stb_o is 1 exactly in the first cycle of each low phase. high_stb_o is 1 exactly in the first cycle of each timed high phase. Each pulses once per period.
- R9: Dropping run_i in the middle of a phase releases SCL in the next cycle.
- R10: With EXT_EN=0, lo_ext_i and hi_ext_i have no effect. The low count 0x103 then gives a 3-cycle low phase at D=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Block clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| run_i | input | 1 | Enables clock generation; low returns the block to idle |
| lo_base_i | input | 8 | Low count, bits 7..0 |
| lo_ext_i | input | 1 | Low count, bit 8 |
| hi_base_i | input | 8 | High count, bits 7..0 |
| hi_ext_i | input | 1 | High count, bit 8 |
| prescale_i | input | PRE_W | Input clocks per count tick |
| scl_i | input | 1 | Sampled SCL line level |
| scl_drive_low_o | output | 1 | Pulls SCL low when 1 |
| low_stb_o | output | 1 | First cycle of a low phase |
| high_stb_o | output | 1 | First cycle of a confirmed high phase |

## Verification
A wrong phase state or a counter left stale shows up at scl_drive_low_o in the same period. The low or released time is off by whole ticks, and this is visible as soon as that phase ends, within at most 511*D cycles. A broken wait for SCL high shows as a released time that does not grow when the line rise is held back. A missed return to low shows one cycle after the line is pulled down during the high phase. Strobe faults show as a pulse count other than one per phase.

// File: rtl/scl_pace_pkg.sv
package scl_pace_pkg;

  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_LOW  = 2'd1,
    PH_RISE = 2'd2,
    PH_HIGH = 2'd3
  } phase_e;

endpackage

// File: rtl/scl_tick_div.sv
module scl_tick_div #(
  parameter int PRE_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic             clr_i,
  input  logic [PRE_W-1:0] div_i,
  output logic             tick_o
);

  logic [PRE_W-1:0] pre_q;
  logic [PRE_W-1:0] lim;

  // zero divides like one
  assign lim    = (div_i == '0) ? '0 : div_i - 1'b1;
  assign tick_o = en_i && (pre_q >= lim);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                      pre_q <= '0;
    else if (!en_i || clr_i || tick_o) pre_q <= '0;
    else                              pre_q <= pre_q + 1'b1;
  end

  p_tick_space_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_o && div_i > 1 && !clr_i) |=> (!tick_o || div_i != $past(div_i)));

endmodule

// File: rtl/scl_phase_cnt.sv
module scl_phase_cnt #(
  parameter int CNT_W = 9
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             tick_i,
  input  logic [CNT_W-1:0] target_i,
  output logic             done_o
);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] last;

  // a zero target still takes one tick
  assign last   = (target_i == '0) ? '0 : target_i - 1'b1;
  assign done_o = tick_i && (cnt_q >= last);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              cnt_q <= '0;
    else if (clr_i || done_o) cnt_q <= '0;
    else if (tick_i)          cnt_q <= cnt_q + 1'b1;
  end

  p_cnt_clear_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_i && !tick_i) |=> !done_o || (target_i <= 1));

endmodule

// File: rtl/scl_phase_fsm.sv
module scl_phase_fsm
  import scl_pace_pkg::*;
(
  input  logic   clk_i,
  input  logic   rst_ni,
  input  logic   run_i,
  input  logic   scl_i,
  input  logic   done_i,
  output phase_e state_o,
  output logic   clr_o,
  output logic   cnt_en_o,
  output logic   drive_low_o,
  output logic   low_stb_o,
  output logic   high_stb_o
);

  phase_e state_q, state_d;
  logic   low_stb_q, high_stb_q;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      PH_IDLE: state_d = PH_LOW;
      PH_LOW:  if (done_i) state_d = PH_RISE;
      PH_RISE: if (scl_i) state_d = PH_HIGH;
      PH_HIGH: if (!scl_i || done_i) state_d = PH_LOW;
      default: state_d = PH_IDLE;
    endcase
    if (!run_i) state_d = PH_IDLE;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q    <= PH_IDLE;
      low_stb_q  <= 1'b0;
      high_stb_q <= 1'b0;
    end else begin
      state_q    <= state_d;
      low_stb_q  <= (state_d == PH_LOW) && (state_q != PH_LOW);
      high_stb_q <= (state_d == PH_HIGH) && (state_q != PH_HIGH);
    end
  end

  assign state_o     = state_q;
  assign clr_o       = (state_d != state_q);
  assign cnt_en_o    = (state_q == PH_LOW) || (state_q == PH_HIGH);
  assign drive_low_o = (state_q == PH_LOW);
  assign low_stb_o   = low_stb_q;
  assign high_stb_o  = high_stb_q;

  p_stretch_low_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == PH_HIGH && !scl_i && run_i) |=> (drive_low_o && low_stb_o));

  p_high_after_scl_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    high_stb_o |-> $past(scl_i));

  p_low_strobe_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(drive_low_o) |-> low_stb_o);

endmodule

// File: rtl/i2c_scl_pacer.sv
module i2c_scl_pacer
  import scl_pace_pkg::*;
#(
  parameter int BASE_W = 8,
  parameter bit EXT_EN = 1'b1,
  parameter int PRE_W  = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              run_i,
  input  logic [BASE_W-1:0] lo_base_i,
  input  logic              lo_ext_i,
  input  logic [BASE_W-1:0] hi_base_i,
  input  logic              hi_ext_i,
  input  logic [PRE_W-1:0]  prescale_i,
  input  logic              scl_i,
  output logic              scl_drive_low_o,
  output logic              low_stb_o,
  output logic              high_stb_o
);

  localparam int CNT_W = BASE_W + 1;

  logic [CNT_W-1:0] lo_cnt, hi_cnt, target;
  phase_e           state;
  logic             clr, cnt_en, tick, done;

  generate
    if (EXT_EN) begin : g_ext
      assign lo_cnt = {lo_ext_i, lo_base_i};
      assign hi_cnt = {hi_ext_i, hi_base_i};
    end else begin : g_noext
      assign lo_cnt = {1'b0, lo_base_i};
      assign hi_cnt = {1'b0, hi_base_i};
    end
  endgenerate

  assign target = (state == PH_HIGH) ? hi_cnt : lo_cnt;

  scl_tick_div #(.PRE_W(PRE_W)) i_div (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .en_i   (cnt_en),
    .clr_i  (clr),
    .div_i  (prescale_i),
    .tick_o (tick)
  );

  scl_phase_cnt #(.CNT_W(CNT_W)) i_cnt (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .clr_i    (clr),
    .tick_i   (tick),
    .target_i (target),
    .done_o   (done)
  );

  scl_phase_fsm i_fsm (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .run_i       (run_i),
    .scl_i       (scl_i),
    .done_i      (done),
    .state_o     (state),
    .clr_o       (clr),
    .cnt_en_o    (cnt_en),
    .drive_low_o (scl_drive_low_o),
    .low_stb_o   (low_stb_o),
    .high_stb_o  (high_stb_o)
  );

  p_idle_release_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run_i |=> (!scl_drive_low_o && !low_stb_o && !high_stb_o));

  p_run_drop_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (scl_drive_low_o && !run_i) |=> !scl_drive_low_o);

endmodule

// File: tb/test_i2c_scl_pacer.sv
module test_i2c_scl_pacer;

  localparam int CLK_PERIOD = 10;
  localparam int NV = 7;
  // columns: low count, high count, prescale, rise hold cycles
  localparam int VEC [NV][4] = '{
    '{4,   3,   1, 0},  // R2 R3 basic
    '{0,   0,   1, 0},  // R5 zero counts
    '{5,   2,   3, 0},  // R6 prescale 3
    '{2,   4,   0, 0},  // R6 prescale zero
    '{300, 1,   1, 0},  // R4 low bit 8
    '{1,   257, 2, 0},  // R4 high bit 8
    '{3,   4,   2, 6}   // R3 slow rise
  };

  logic       clk = 1'b0;
  logic       rst_n;
  logic       run_a, run_b, hold_a;
  logic [7:0] lo_base, hi_base, pre;
  logic       lo_ext, hi_ext;
  logic       drv_a, lstb_a, hstb_a, scl_a;
  logic       drv_b, lstb_b, hstb_b, scl_b;
  int         errors = 0;
  int         checks = 0;
  int         cycles = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  assign scl_a = ~drv_a & ~hold_a;
  assign scl_b = ~drv_b;

  i2c_scl_pacer i_i2c_scl_pacer (
    .clk_i(clk), .rst_ni(rst_n), .run_i(run_a),
    .lo_base_i(lo_base), .lo_ext_i(lo_ext),
    .hi_base_i(hi_base), .hi_ext_i(hi_ext),
    .prescale_i(pre), .scl_i(scl_a),
    .scl_drive_low_o(drv_a), .low_stb_o(lstb_a), .high_stb_o(hstb_a)
  );

  i2c_scl_pacer #(.EXT_EN(1'b0)) i_i2c_scl_pacer_noext (
    .clk_i(clk), .rst_ni(rst_n), .run_i(run_b),
    .lo_base_i(lo_base), .lo_ext_i(lo_ext),
    .hi_base_i(hi_base), .hi_ext_i(hi_ext),
    .prescale_i(pre), .scl_i(scl_b),
    .scl_drive_low_o(drv_b), .low_stb_o(lstb_b), .high_stb_o(hstb_b)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int at_least1(input int v);
    return (v < 1) ? 1 : v;
  endfunction

  task automatic measure(input int hold_n, output int lo_n, output int rel_n,
                         output int ls, output int hs);
    int g;
    lo_n = 0; rel_n = 0; ls = 0; hs = 0; g = 0;
    hold_a = (hold_n > 1);
    @(negedge clk);
    while (!drv_a && g < 3000) begin @(negedge clk); g++; end
    while (drv_a && lo_n < 3000) begin
      lo_n++; ls += int'(lstb_a); @(negedge clk);
    end
    while (!drv_a && rel_n < 3000) begin
      rel_n++; hs += int'(hstb_a);
      if (rel_n >= hold_n) hold_a = 1'b0;
      @(negedge clk);
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=%0d expected=%0d", cycles, 150000);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    int lo_n, rel_n, ls, hs, n;
    rst_n = 1'b0; run_a = 1'b0; run_b = 1'b0; hold_a = 1'b0;
    lo_base = 8'd1; hi_base = 8'd1; lo_ext = 1'b0; hi_ext = 1'b0; pre = 8'd1;
    repeat (3) @(negedge clk);
    chk(!drv_a && !lstb_a && !hstb_a, "R1 reset outputs", int'(drv_a), 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(!drv_a && !lstb_a && !hstb_a, "R1 idle without run", int'(drv_a), 0);

    for (int i = 0; i < NV; i++) begin
      logic [8:0] lv, hv;
      int el, er;
      lv = 9'(VEC[i][0]); hv = 9'(VEC[i][1]);
      lo_base = lv[7:0]; lo_ext = lv[8];
      hi_base = hv[7:0]; hi_ext = hv[8];
      pre = 8'(VEC[i][2]);
      el = at_least1(VEC[i][0]) * at_least1(VEC[i][2]);
      er = at_least1(VEC[i][3]) + at_least1(VEC[i][1]) * at_least1(VEC[i][2]);
      run_a = 1'b1;
      measure(VEC[i][3], lo_n, rel_n, ls, hs);
      chk(lo_n == el, "R2 low length", lo_n, el);
      chk(rel_n == er, "R3 released length", rel_n, er);
      chk(ls == 1, "R8 low strobe count", ls, 1);
      chk(hs == 1, "R8 high strobe count", hs, 1);
      run_a = 1'b0;
      @(negedge clk);
      chk(!drv_a && !lstb_a && !hstb_a, "R1 stop releases", int'(drv_a), 0);
      repeat (2) @(negedge clk);
    end

    // R7: pull SCL low during the timed high phase
    lo_base = 8'd2; lo_ext = 1'b0; hi_base = 8'd8; hi_ext = 1'b0; pre = 8'd1;
    run_a = 1'b1;
    n = 0;
    @(negedge clk);
    while (!hstb_a && n < 100) begin @(negedge clk); n++; end
    chk(hstb_a && !drv_a, "R8 high strobe seen", int'(hstb_a), 1);
    @(negedge clk);
    hold_a = 1'b1;
    @(negedge clk);
    chk(drv_a && lstb_a, "R7 stretch returns low", int'(drv_a), 1);
    hold_a = 1'b0;
    n = 0;
    while (drv_a && n < 100) begin n++; @(negedge clk); end
    chk(n == 2, "R7 full low after stretch", n, 2);
    run_a = 1'b0;
    repeat (3) @(negedge clk);

    // R9: drop run in the middle of a long low phase
    lo_base = 8'd100; pre = 8'd1;
    run_a = 1'b1;
    repeat (5) @(negedge clk);
    chk(drv_a, "R9 low in progress", int'(drv_a), 1);
    run_a = 1'b0;
    @(negedge clk);
    chk(!drv_a && !lstb_a, "R9 released after run drop", int'(drv_a), 0);
    repeat (3) @(negedge clk);
    chk(!drv_a, "R9 stays released", int'(drv_a), 0);

    // R10: variant without bit 8 ignores the extension inputs
    lo_base = 8'd3; lo_ext = 1'b1; hi_base = 8'd2; hi_ext = 1'b1; pre = 8'd1;
    run_b = 1'b1;
    n = 0;
    @(negedge clk);
    while (!drv_b && n < 100) begin @(negedge clk); n++; end
    n = 0;
    while (drv_b && n < 600) begin n++; @(negedge clk); end
    chk(n == 3, "R10 low ignores ext bit", n, 3);
    n = 0;
    while (!drv_b && n < 600) begin n++; @(negedge clk); end
    chk(n == 3, "R10 high ignores ext bit", n, 3);
    run_b = 1'b0;
    @(negedge clk);
    chk(!drv_b, "R1 variant stop releases", int'(drv_b), 0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule